// File: doc/BRIEF.md
# Wavefront Crossbar Allocator

This block decides, once per epoch, which source cards of a switched backplane may send a cell to which destination cards. Each epoch it samples a square matrix of requests (bit `src*N_PORTS+dst` set means source `src` holds a cell for destination `dst`), a matching matrix of class bits marking requests issued by a forwarding engine, and a per-destination inhibit vector. It returns a conflict-free grant matrix in which every source and every destination appears at most once.

The request matrix is cut into rectangular groups of `GRP_ROWS` x `GRP_COLS` cells. Groups that lie on the same group anti-diagonal share no row and no column, so they are resolved together in one allocation tick. Inside a group a short combinational chain settles the cells: first all forwarding-engine requests, then all line-card requests, each pass in row-major order. Rows and columns already claimed by an earlier tick are skipped. With the default 15 ports and 3x5 groups, seven ticks cover the matrix instead of 29 cell diagonals. To spread the advantage of the early cells fairly, row and column indices are rotated each epoch by an offset taken from a 4-bit LFSR.

Top module: `xbar_wavefront_alloc`

## Requirements
- R1: In every presented grant matrix each source row and each destination column has at most one bit set.
- R2: A grant bit is set only when the matching request bit was set at the epoch's sampling edge.
- R3: A destination whose `inhibit_i` bit was set at the sampling edge receives no grant in that epoch.
- R4: The grant matrix equals the result of this procedure. Shuffled row r maps to source (r+off) mod N_PORTS and shuffled column c maps to destination (c+off) mod N_PORTS. Group (gr,gc) covers shuffled rows gr*GRP_ROWS to gr*GRP_ROWS+GRP_ROWS-1 and shuffled columns gc*GRP_COLS to gc*GRP_COLS+GRP_COLS-1. Groups are taken in increasing order of gr+gc. A requested cell is granted when its shuffled row and shuffled column are still unclaimed, and a grant claims both.
- R5: Inside one group, every request with its `fe_i` bit set is considered before any request with the bit clear. Within each class the cells are taken in row-major order of shuffled local coordinates.
- R6: The offset comes from a 4-bit LFSR that is reset to 4'b0001 and steps as next = {s[2:0], s[3]^s[2]} once per epoch at the sampling edge. The epoch's offset is the LFSR value before that step, with 15 mapped to 0.
- R7: `valid_o` is high for exactly one cycle in every `EPOCH_TICKS` cycles. The first pulse comes `EPOCH_TICKS` clock edges after reset is released. `grant_o` changes only on the edge that raises `valid_o`.
- R8: Inputs are sampled only at the first edge of each epoch. Changes to `req_i`, `fe_i` or `inhibit_i` later in the epoch have no effect on that epoch's grants.
- R9: While reset is applied, and in the first cycle after it is released, `grant_o` is all zero and `valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Allocation clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_PORTS*N_PORTS | Request matrix, bit src*N_PORTS+dst |
| fe_i | input | N_PORTS*N_PORTS | Request class, 1 = forwarding engine, same indexing |
| inhibit_i | input | N_PORTS | Per-destination inhibit |
| grant_o | output | N_PORTS*N_PORTS | Registered grant matrix, same indexing |
| valid_o | output | 1 | One-cycle strobe marking a new grant matrix |

## Verification
A full request matrix shows whether the rotation and the group order pick the exact permutation that the offset predicts. Empty, single-cell and fully inhibited matrices separate masking errors from ordering errors. A directed pair of requests for one destination, placed in the same group with the line-card request ahead of the forwarding-engine one, detects lost class priority. Random matrices of several densities and class mixes, plus an epoch whose inputs change after sampling, check both conflict freedom and the procedure across all offsets.

// File: rtl/xbar_alloc_pkg.sv
`timescale 1ns/1ps
package xbar_alloc_pkg;

   // index arithmetic modulo n for operands already in [0, n)
   function automatic int wrap_add(input int a, input int b, input int n);
      int t;
      t = a + b;
      return (t >= n) ? t - n : t;
   endfunction

   function automatic int wrap_sub(input int a, input int b, input int n);
      int t;
      t = a - b;
      return (t < 0) ? t + n : t;
   endfunction

endpackage

// File: rtl/xbar_alloc_phase.sv
`timescale 1ns/1ps
module xbar_alloc_phase #(
   parameter int EPOCH_TICKS = 8,
   localparam int CNT_W = $clog2(EPOCH_TICKS)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   output logic [CNT_W-1:0] cnt_o,
   output logic             start_o,
   output logic             last_o
);

   if (EPOCH_TICKS < 2) begin : g_bad_epoch
      $error("EPOCH_TICKS must be at least 2");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         cnt_o <= '0;
      else if (last_o)
         cnt_o <= '0;
      else
         cnt_o <= cnt_o + 1'b1;
   end

   assign start_o = (cnt_o == '0);
   assign last_o  = (cnt_o == CNT_W'(EPOCH_TICKS - 1));

endmodule

// File: rtl/xbar_alloc_lfsr.sv
`timescale 1ns/1ps
module xbar_alloc_lfsr #(
   parameter int N_PORTS = 15,
   parameter int LFSR_W  = 4,
   localparam int IDX_W  = $clog2(N_PORTS)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             adv_i,
   output logic [IDX_W-1:0] off_o
);

   logic [LFSR_W-1:0] st_q, st_n;

   if ((2 ** LFSR_W) - 1 < N_PORTS) begin : g_bad_len
      $error("LFSR period shorter than port count");
   end

   if (LFSR_W == 4) begin : g_w4
      assign st_n = {st_q[2:0], st_q[3] ^ st_q[2]};
   end else if (LFSR_W == 5) begin : g_w5
      assign st_n = {st_q[3:0], st_q[4] ^ st_q[2]};
   end else begin : g_wbad
      assign st_n = st_q;
      $error("LFSR_W must be 4 or 5");
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
         st_q <= LFSR_W'(1);
      else if (adv_i)
         st_q <= st_n;
   end

   assign off_o = IDX_W'(32'(st_q) % N_PORTS);

endmodule

// File: rtl/xbar_alloc_group.sv
`timescale 1ns/1ps
module xbar_alloc_group #(
   parameter int ROWS = 3,
   parameter int COLS = 5,
   localparam int CELLS = ROWS * COLS
) (
   input  logic             active_i,
   input  logic [CELLS-1:0] req_i,
   input  logic [CELLS-1:0] fe_i,
   input  logic [ROWS-1:0]  row_busy_i,
   input  logic [COLS-1:0]  col_busy_i,
   output logic [CELLS-1:0] gnt_o
);

   logic [ROWS-1:0] rb;
   logic [COLS-1:0] cb;

   // pass 0 serves forwarding-engine requests, pass 1 line-card requests
   always_comb begin
      rb    = row_busy_i;
      cb    = col_busy_i;
      gnt_o = '0;
      for (int p = 0; p < 2; p++) begin
         for (int lr = 0; lr < ROWS; lr++) begin
            for (int lc = 0; lc < COLS; lc++) begin
               if (active_i && req_i[lr*COLS+lc] && (fe_i[lr*COLS+lc] == (p == 0))
                   && !rb[lr] && !cb[lc]) begin
                  gnt_o[lr*COLS+lc] = 1'b1;
                  rb[lr]            = 1'b1;
                  cb[lc]            = 1'b1;
               end
            end
         end
      end
   end

endmodule

// File: rtl/xbar_wavefront_alloc.sv
`timescale 1ns/1ps
module xbar_wavefront_alloc
   import xbar_alloc_pkg::*;
#(
   parameter int N_PORTS     = 15,
   parameter int GRP_ROWS    = 3,
   parameter int GRP_COLS    = 5,
   parameter int EPOCH_TICKS = 8,
   parameter int LFSR_W      = 4
) (
   input  logic                         clk_i,
   input  logic                         rst_ni,
   input  logic [N_PORTS*N_PORTS-1:0]   req_i,
   input  logic [N_PORTS*N_PORTS-1:0]   fe_i,
   input  logic [N_PORTS-1:0]           inhibit_i,
   output logic [N_PORTS*N_PORTS-1:0]   grant_o,
   output logic                         valid_o
);

   localparam int NN    = N_PORTS * N_PORTS;
   localparam int NGR   = N_PORTS / GRP_ROWS;
   localparam int NGC   = N_PORTS / GRP_COLS;
   localparam int NDIAG = NGR + NGC - 1;
   localparam int CNT_W = $clog2(EPOCH_TICKS);
   localparam int IDX_W = $clog2(N_PORTS);

   if (N_PORTS % GRP_ROWS != 0) begin : g_bad_rows
      $error("GRP_ROWS must divide N_PORTS");
   end
   if (N_PORTS % GRP_COLS != 0) begin : g_bad_cols
      $error("GRP_COLS must divide N_PORTS");
   end
   if (EPOCH_TICKS < NDIAG + 1) begin : g_bad_ticks
      $error("epoch too short for the group wavefront");
   end

   logic [CNT_W-1:0] cnt;
   logic             start, last;
   logic [IDX_W-1:0] off_now, off_q;
   logic [NN-1:0]    sreq_q, sfe_q, sg_q, ng, sgf;
   logic [NN-1:0]    sreq_n, sfe_n, grant_n;
   logic [N_PORTS-1:0] rclaim_q, cclaim_q, rclaim_n, cclaim_n;

   xbar_alloc_phase #(.EPOCH_TICKS(EPOCH_TICKS)) u_phase (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .cnt_o   (cnt),
      .start_o (start),
      .last_o  (last)
   );

   xbar_alloc_lfsr #(.N_PORTS(N_PORTS), .LFSR_W(LFSR_W)) u_lfsr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .adv_i  (start),
      .off_o  (off_now)
   );

   // inhibit masking, then rotation into shuffled coordinates
   always_comb begin
      int s, d;
      for (int r = 0; r < N_PORTS; r++) begin
         for (int c = 0; c < N_PORTS; c++) begin
            s = wrap_add(r, int'(off_now), N_PORTS);
            d = wrap_add(c, int'(off_now), N_PORTS);
            sreq_n[r*N_PORTS+c] = req_i[s*N_PORTS+d] & ~inhibit_i[d];
            sfe_n[r*N_PORTS+c]  = fe_i[s*N_PORTS+d];
         end
      end
   end

   // group array: one anti-diagonal of groups is active per tick
   for (genvar gr = 0; gr < NGR; gr++) begin : g_grow
      for (genvar gc = 0; gc < NGC; gc++) begin : g_gcol
         localparam int R0 = gr * GRP_ROWS;
         localparam int C0 = gc * GRP_COLS;
         logic [GRP_ROWS*GRP_COLS-1:0] g_req, g_fe, g_gnt;
         logic                         g_act;

         assign g_act = (cnt == CNT_W'(gr + gc + 1));

         for (genvar lr = 0; lr < GRP_ROWS; lr++) begin : g_lr
            for (genvar lc = 0; lc < GRP_COLS; lc++) begin : g_lc
               assign g_req[lr*GRP_COLS+lc]       = sreq_q[(R0+lr)*N_PORTS + C0 + lc];
               assign g_fe[lr*GRP_COLS+lc]        = sfe_q[(R0+lr)*N_PORTS + C0 + lc];
               assign ng[(R0+lr)*N_PORTS + C0 + lc] = g_gnt[lr*GRP_COLS+lc];
            end
         end

         xbar_alloc_group #(.ROWS(GRP_ROWS), .COLS(GRP_COLS)) u_grp (
            .active_i   (g_act),
            .req_i      (g_req),
            .fe_i       (g_fe),
            .row_busy_i (rclaim_q[R0 +: GRP_ROWS]),
            .col_busy_i (cclaim_q[C0 +: GRP_COLS]),
            .gnt_o      (g_gnt)
         );
      end
   end

   assign sgf = sg_q | ng;

   always_comb begin
      rclaim_n = rclaim_q;
      cclaim_n = cclaim_q;
      for (int r = 0; r < N_PORTS; r++) begin
         for (int c = 0; c < N_PORTS; c++) begin
            if (ng[r*N_PORTS+c]) begin
               rclaim_n[r] = 1'b1;
               cclaim_n[c] = 1'b1;
            end
         end
      end
   end

   // rotate back to port coordinates
   always_comb begin
      int rs, rd;
      for (int s = 0; s < N_PORTS; s++) begin
         for (int d = 0; d < N_PORTS; d++) begin
            rs = wrap_sub(s, int'(off_q), N_PORTS);
            rd = wrap_sub(d, int'(off_q), N_PORTS);
            grant_n[s*N_PORTS+d] = sgf[rs*N_PORTS+rd];
         end
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         sreq_q   <= '0;
         sfe_q    <= '0;
         sg_q     <= '0;
         rclaim_q <= '0;
         cclaim_q <= '0;
         off_q    <= '0;
         grant_o  <= '0;
         valid_o  <= 1'b0;
      end else begin
         valid_o <= 1'b0;
         if (start) begin
            sreq_q   <= sreq_n;
            sfe_q    <= sfe_n;
            sg_q     <= '0;
            rclaim_q <= '0;
            cclaim_q <= '0;
            off_q    <= off_now;
         end else begin
            sg_q     <= sgf;
            rclaim_q <= rclaim_n;
            cclaim_q <= cclaim_n;
         end
         if (last) begin
            grant_o <= grant_n;
            valid_o <= 1'b1;
         end
      end
   end

endmodule

// File: rtl/xbar_wavefront_alloc_chk.sv
`timescale 1ns/1ps
module xbar_wavefront_alloc_chk #(
   parameter int N_PORTS     = 15,
   parameter int EPOCH_TICKS = 8,
   localparam int NN    = N_PORTS * N_PORTS,
   localparam int CNT_W = $clog2(EPOCH_TICKS)
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic [NN-1:0]    req_i,
   input logic [N_PORTS-1:0] inhibit_i,
   input logic [NN-1:0]    grant_o,
   input logic             valid_o,
   input logic [CNT_W-1:0] cnt_i
);

   logic [NN-1:0]      ck_req;
   logic [N_PORTS-1:0] ck_inh;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ck_req <= '0;
         ck_inh <= '0;
      end else if (cnt_i == '0) begin
         ck_req <= req_i;
         ck_inh <= inhibit_i;
      end
   end

   // R7
   strobe_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> (cnt_i == '0));
   // R7
   strobe_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |=> !valid_o);
   // R7
   grant_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !valid_o |-> $stable(grant_o));
   // R2
   grant_requested_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> ((grant_o & ~ck_req) == '0));

   for (genvar k = 0; k < N_PORTS; k++) begin : g_line
      logic [N_PORTS-1:0] row_bits, col_bits;
      for (genvar m = 0; m < N_PORTS; m++) begin : g_bit
         assign row_bits[m] = grant_o[k*N_PORTS+m];
         assign col_bits[m] = grant_o[m*N_PORTS+k];
      end
      // R1
      src_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         valid_o |-> $onehot0(row_bits));
      // R1
      dst_once_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         valid_o |-> $onehot0(col_bits));
      // R3
      inhibit_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (valid_o && ck_inh[k]) |-> (col_bits == '0));
   end

endmodule

bind xbar_wavefront_alloc xbar_wavefront_alloc_chk #(
   .N_PORTS     (N_PORTS),
   .EPOCH_TICKS (EPOCH_TICKS)
) u_chk (
   .clk_i     (clk_i),
   .rst_ni    (rst_ni),
   .req_i     (req_i),
   .inhibit_i (inhibit_i),
   .grant_o   (grant_o),
   .valid_o   (valid_o),
   .cnt_i     (cnt)
);

// File: tb/xbar_wavefront_alloc_tb_top.sv
`timescale 1ns/1ps
module xbar_wavefront_alloc_tb_top;

   localparam int N     = 15;
   localparam int GR    = 3;
   localparam int GC    = 5;
   localparam int EP    = 8;
   localparam int NN    = N * N;
   localparam int NGR   = N / GR;
   localparam int NGC   = N / GC;

   logic          clk = 1'b0;
   logic          rst_ni;
   logic [NN-1:0] req, fe, grant;
   logic [N-1:0]  inh;
   logic          valid;

   int       errors = 0;
   int       checks = 0;
   bit       done   = 1'b0;
   logic [3:0]    lfsr_m;
   logic [NN-1:0] last_exp;

   always #2 clk = ~clk;   // 4 ns period, 250 MHz

   xbar_wavefront_alloc #(
      .N_PORTS(N), .GRP_ROWS(GR), .GRP_COLS(GC), .EPOCH_TICKS(EP), .LFSR_W(4)
   ) dut_i (
      .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .fe_i(fe),
      .inhibit_i(inh), .grant_o(grant), .valid_o(valid)
   );

   task automatic chk(input bit ok, input string tag, input logic [NN-1:0] act,
                      input logic [NN-1:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // R6 offset model
   function automatic int peek_off();
      return (lfsr_m == 4'd15) ? 0 : int'(lfsr_m);
   endfunction

   // R4/R5 allocation model
   function automatic logic [NN-1:0] model(input logic [NN-1:0] rq, input logic [NN-1:0] f,
                                           input logic [N-1:0] ih, input int off);
      bit rb[N];
      bit cb[N];
      logic [NN-1:0] g;
      int r, c, s, d;
      g = '0;
      for (int i = 0; i < N; i++) begin rb[i] = 0; cb[i] = 0; end
      for (int gd = 0; gd < NGR + NGC - 1; gd++)
         for (int gr = 0; gr < NGR; gr++) begin
            int gc;
            gc = gd - gr;
            if (gc >= 0 && gc < NGC)
               for (int p = 0; p < 2; p++)
                  for (int lr = 0; lr < GR; lr++)
                     for (int lc = 0; lc < GC; lc++) begin
                        r = gr*GR + lr; c = gc*GC + lc;
                        s = (r + off) % N; d = (c + off) % N;
                        if (rq[s*N+d] && !ih[d] && (f[s*N+d] == (p == 0)) && !rb[r] && !cb[c]) begin
                           g[s*N+d] = 1'b1; rb[r] = 1; cb[c] = 1;
                        end
                     end
         end
      return g;
   endfunction

   function automatic bit lines_ok(input logic [NN-1:0] g);
      for (int k = 0; k < N; k++) begin
         int rs, cs;
         rs = 0; cs = 0;
         for (int m = 0; m < N; m++) begin
            rs += int'(g[k*N+m]);
            cs += int'(g[m*N+k]);
         end
         if (rs > 1 || cs > 1) return 1'b0;
      end
      return 1'b1;
   endfunction

   // called at the negedge just before an epoch's sampling edge
   task automatic run_epoch(input logic [NN-1:0] rq, input logic [NN-1:0] f,
                            input logic [N-1:0] ih, input logic [NN-1:0] rq2,
                            input bit chg, input string tag);
      logic [NN-1:0] exp;
      bit bad_valid, hold_bad;
      exp = model(rq, f, ih, peek_off());
      lfsr_m = {lfsr_m[2:0], lfsr_m[3] ^ lfsr_m[2]};
      req = rq; fe = f; inh = ih;
      bad_valid = 0; hold_bad = 0;
      for (int k = 1; k <= EP; k++) begin
         @(negedge clk);
         if (chg && k == 2) begin   // R8 late change
            req = rq2; fe = ~f; inh = ~ih;
         end
         if (k < EP) begin
            if (valid !== 1'b0) bad_valid = 1;
            if (grant !== last_exp) hold_bad = 1;
         end
      end
      chk(valid === 1'b1 && !bad_valid, "R7 strobe", {224'd0, valid}, {224'd0, 1'b1});
      chk(!hold_bad, "R7 hold", grant, last_exp);
      chk(grant === exp, tag, grant, exp);
      chk(lines_ok(grant), "R1 conflict", grant, exp);
      last_exp = exp;
   endtask

   initial begin
      #(4 * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [NN-1:0] ones, one_cell, rr, ff;
      logic [N-1:0]  ih;
      int o, s0, s1, d;
      bit colbad;
      void'($urandom(32'h5eed_0a11));
      ones = '1;
      rst_ni = 1'b0; req = '0; fe = '0; inh = '0;
      lfsr_m = 4'd1; last_exp = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(grant === '0 && valid === 1'b0, "R9 reset", grant, '0);
      rst_ni = 1'b1;
      @(negedge clk);
      chk(grant === '0 && valid === 1'b0, "R9 after release", grant, '0);
      // realign: the first sampling edge already passed; finish epoch 0
      for (int k = 2; k <= EP; k++) @(negedge clk);
      chk(valid === 1'b1 && grant === '0, "R7 first strobe", grant, '0);
      lfsr_m = {lfsr_m[2:0], lfsr_m[3] ^ lfsr_m[2]};

      run_epoch('0, '0, '0, '0, 0, "R2 empty");
      run_epoch(ones, '0, '0, '0, 0, "R6 full matrix rotation");
      run_epoch(ones, '0, '1, '0, 0, "R3 all inhibited");
      ih = 15'h5555;
      run_epoch(ones, '0, ih, '0, 0, "R3 alternate inhibit");
      colbad = 0;
      for (int k = 0; k < N; k++)
         if (ih[k]) for (int m = 0; m < N; m++) if (grant[m*N+k]) colbad = 1;
      chk(!colbad, "R3 inhibited column", grant, '0);
      one_cell = '0; one_cell[14*N+14] = 1'b1;
      run_epoch(one_cell, '0, '0, '0, 0, "R2 single cell");
      chk(grant === one_cell, "R2 single exact", grant, one_cell);

      o = peek_off(); s0 = o % N; s1 = (1 + o) % N; d = o;
      rr = '0; ff = '0;
      rr[s0*N+d] = 1'b1; rr[s1*N+d] = 1'b1; ff[s1*N+d] = 1'b1;
      run_epoch(rr, ff, '0, '0, 0, "R5 class priority");
      chk(grant[s1*N+d] === 1'b1 && grant[s0*N+d] === 1'b0, "R5 engine wins", grant, ff);

      one_cell = '0; one_cell[3*N+7] = 1'b1;
      run_epoch(one_cell, '0, '0, ones, 1, "R8 late change ignored");
      run_epoch(ones, ones, '0, '0, 0, "R5 all engine");

      for (int e = 0; e < 40; e++) begin
         int dens;
         dens = (e % 4) * 25 + 10;
         for (int i = 0; i < NN; i++) begin
            rr[i] = ($urandom_range(99) < dens);
            ff[i] = ($urandom_range(99) < 40);
         end
         for (int i = 0; i < N; i++) ih[i] = ($urandom_range(99) < 15);
         run_epoch(rr, ff, ih, '0, 0, "R4 random");
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule